// File: doc/BRIEF.md
# Serial 1001 Pattern Detector

This block watches a one-bit serial stream, sampled once per rising clock edge, and raises a flag while its state register holds the state that completes the pattern 1, 0, 0, 1. It is a Moore machine. The flag depends only on the stored state, so it is glitch-free and cannot change while the serial input toggles between clock edges.

Five states, binary 0 to 4, are kept in a three-bit register. The transition rules are fixed. A run of ones keeps the partial match at its first step. A one that follows "1 0" falls back to the first step. A zero that follows "1 0 0" returns to idle. After a full match, a one starts a new match, while a zero returns to idle. Encodings 5 to 7 are never entered, and if they are held they go to idle on the next clock. An active-low asynchronous reset forces idle.

Top module: `pat_det`

## Requirements
- R1: While rst_ni is low, the machine is idle (state 0) and match_o is 0. After reset is released, the stream 0,0,1 produces no match.
- R2: After the clock edge that samples the final 1 of the sequence 1,0,0,1 from idle, match_o is 1 for that cycle.
- R3: A run of extra ones before the zeros keeps the partial match. The stream 1,1,1,0,0,1 raises match_o after its last bit.
- R4: A 1 after the prefix 1,0 restarts the partial match at its first step. The stream 1,0,1,0,0,1 raises match_o after its last bit.
- R5: A 0 after the prefix 1,0,0 returns the machine to idle. The stream 1,0,0,0,1 leaves match_o at 0.
- R6: In the match state, a sampled 1 moves to the first-step state and a sampled 0 moves to idle. The stream 1,0,0,1,1,0,0,1 matches twice. The stream 1,0,0,1,0,0,1 matches only once.
- R7: match_o is high for one cycle at a time. It is a function of the stored state alone: a change on bit_i between edges leaves match_o unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial input bit, sampled on each rising edge |
| match_o | output | 1 | High while the machine sits in the match state |

## Verification
Each bit is applied at the falling edge. It is registered at the next rising edge, and match_o for that bit is due in the cycle that follows that edge, with no further delay. The bench therefore compares match_o at the next falling edge against a bench model stepped once per applied bit. For the R7 checks, bit_i is flipped a short time after the rising edge, and match_o is compared at the following falling edge, before the flipped value can be sampled.

// File: rtl/pat_det_pkg.sv
package pat_det_pkg;
  localparam int unsigned NUM_STATES = 5;
  localparam int unsigned STATE_W    = $clog2(NUM_STATES);

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 3'd0,
    ST_ONE  = 3'd1,
    ST_ZERO = 3'd2,
    ST_ZZ   = 3'd3,
    ST_HIT  = 3'd4
  } state_e;
endpackage

// File: rtl/pat_det_next.sv
module pat_det_next
  import pat_det_pkg::*;
(
  input  logic [STATE_W-1:0] state_i,
  input  logic               bit_i,
  output logic [STATE_W-1:0] state_o
);
  always_comb begin
    unique case (state_i)
      ST_IDLE: state_o = bit_i ? ST_ONE  : ST_IDLE;
      ST_ONE:  state_o = bit_i ? ST_ONE  : ST_ZERO;
      ST_ZERO: state_o = bit_i ? ST_ONE  : ST_ZZ;
      ST_ZZ:   state_o = bit_i ? ST_HIT  : ST_IDLE;
      ST_HIT:  state_o = bit_i ? ST_ONE  : ST_IDLE;
      default: state_o = ST_IDLE; // unused codes recover to idle
    endcase
  end
endmodule

// File: rtl/pat_det_out.sv
module pat_det_out
  import pat_det_pkg::*;
(
  input  logic [STATE_W-1:0] state_i,
  output logic               match_o
);
  assign match_o = (state_i == ST_HIT);
endmodule

// File: rtl/pat_det.sv
module pat_det
  import pat_det_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  output logic match_o
);
  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] state_d;

  pat_det_next u_next (
    .state_i (state_q),
    .bit_i   (bit_i),
    .state_o (state_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  pat_det_out u_out (
    .state_i (state_q),
    .match_o (match_o)
  );
endmodule

// File: rtl/pat_det_chk.sv
module pat_det_chk
  import pat_det_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bit_i,
  input logic [STATE_W-1:0] state_i,
  input logic               match_o
);
  always_comb begin
    if (!rst_ni) assert_reset_idle_R1: assert (match_o == 1'b0);
  end

  assert_hit_after_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ZZ && bit_i) |=> match_o);

  assert_ones_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ONE && bit_i) |=> (state_i == ST_ONE));

  assert_retry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ZERO && bit_i) |=> (state_i == ST_ONE));

  assert_abort_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ZZ && !bit_i) |=> (state_i == ST_IDLE && !match_o));

  assert_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && bit_i) |=> (state_i == ST_ONE));

  assert_single_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> !match_o);

  assert_legal_state_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i <= ST_HIT);
endmodule

bind pat_det pat_det_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .bit_i   (bit_i),
  .state_i (state_q),
  .match_o (match_o)
);

// File: tb/pat_det_tb_top.sv
`timescale 1ns/1ps
module pat_det_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_i = 1'b0;
  logic match_o;

  int n_chk = 0;
  int n_bad = 0;
  int mstate = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  pat_det dut_i (.clk_i(clk_i), .rst_ni(rst_ni), .bit_i(bit_i), .match_o(match_o));

  // Reference transitions written from the requirements
  function automatic int ref_next(int s, logic b);
    case (s)
      0: return b ? 1 : 0;
      1: return b ? 1 : 2;
      2: return b ? 1 : 3;
      3: return b ? 4 : 0;
      4: return b ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic check(logic act, logic exp, string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: match_o=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // drive at falling edge, result due at the next falling edge
  task automatic send(logic b, string req, bit wiggle = 1'b0);
    bit_i = b;
    mstate = ref_next(mstate, b);
    @(posedge clk_i);
    if (wiggle) begin
      #2 bit_i = ~b;
    end
    @(negedge clk_i);
    check(match_o, logic'(mstate == 4), req);
  endtask

  task automatic send_seq(logic [15:0] pat, int len, string req);
    for (int i = len - 1; i >= 0; i--) send(pat[i], req);
  endtask

  task automatic flush();
    for (int i = 0; i < 4; i++) send(1'b0, "flush");
  endtask

  initial begin
    void'($urandom(32'h1001));
    repeat (3) @(negedge clk_i);
    check(match_o, 1'b0, "R1");
    rst_ni = 1'b1;
    mstate = 0;
    send_seq(16'b001, 3, "R1");

    flush();
    send_seq(16'b1001, 4, "R2");
    check(match_o, 1'b1, "R2");
    flush();
    send_seq(16'b111001, 6, "R3");
    check(match_o, 1'b1, "R3");
    flush();
    send_seq(16'b101001, 6, "R4");
    check(match_o, 1'b1, "R4");
    flush();
    send_seq(16'b10001, 5, "R5");
    check(match_o, 1'b0, "R5");
    flush();
    send_seq(16'b10011001, 8, "R6");
    check(match_o, 1'b1, "R6");
    flush();
    send_seq(16'b1001001, 7, "R6");
    check(match_o, 1'b0, "R6");
    flush();

    // R7: toggle bit_i between edges, including in the hit state
    send(1'b1, "R7", 1'b1);
    send(1'b0, "R7", 1'b1);
    send(1'b0, "R7", 1'b1);
    send(1'b1, "R7", 1'b1);
    send(1'b1, "R7", 1'b1);

    // mid-run reset returns to idle
    send_seq(16'b100, 3, "R1");
    rst_ni = 1'b0;
    mstate = 0;
    #1;
    check(match_o, 1'b0, "R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    send(1'b1, "R1");

    // random stream, biased towards the pattern
    for (int i = 0; i < 3000; i++) begin
      logic b;
      if ($urandom_range(0, 3) == 0) begin
        send_seq(16'b1001, 4, "R2");
      end else begin
        b = logic'($urandom_range(0, 1));
        send(b, "R6", ($urandom_range(0, 7) == 0));
      end
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule